// File: doc/BRIEF.md
# Stream Identifier Span Match Filter

This block decides, for each event counter of a performance-monitoring group, whether a transaction carrying a given stream identifier should be counted. Each counter supplies a match pattern and a span flag. With the span flag clear, the identifier must equal the pattern bit for bit. With the span flag set, the pattern also encodes how many low-order identifier bits are don't-care: the pattern's lowest zero bit marks the top of the wildcard run. That zero bit, and the ones below it, stand for "any value". The bits above the zero are compared normally.

The block also chooses where each counter's filter comes from. In per-counter scope every counter uses its own pattern and span. In global scope, the pattern and span of counter 0 serve every counter, and the other counters' settings play no part. A pattern of all ones with the span flag set matches every identifier, which is how an unfiltered counter is configured. The per-counter match flags come out of an optional output register. The register lets the flags line up with a registered event strobe.

Top module: `sidf_stream_match`

## Requirements
- R1: With the span flag of the selected filter at 0, `match_o[i]` is 1 exactly when every one of the SID_W identifier bits equals the corresponding pattern bit.
- R2: With the span flag at 1 and the lowest zero of the pattern at bit position Y-1 (all bits below it ones), identifier bits Y-1..0 are ignored and `match_o[i]` is 1 exactly when identifier bits SID_W-1..Y equal the pattern bits.
- R3: With the span flag at 1 and pattern 0x00000042, the identifiers 0x42 and 0x43 match, and every other identifier does not.
- R4: With the span flag at 1 and a pattern that has no zero bit (all ones), every identifier matches.
- R5: With `global_mode` at 0, counter i is filtered by its own pattern, taken from `ctr_pattern[i*SID_W +: SID_W]`, and by its own span flag `ctr_span[i]`.
- R6: With `global_mode` at 1, every counter is filtered by the pattern and span flag of counter 0, so all bits of `match_o` are equal. The patterns and span flags of counters 1..NUM_CTR-1 have no effect.
- R7: With OUT_REG=1 (the default), `match_o` shows the result for the inputs sampled at a rising clock edge from that edge until the next one. With OUT_REG=0, `match_o` follows the inputs combinationally.
- R8: A rising edge with `rst_n` low clears every bit of `match_o` to 0 when OUT_REG=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_sid | input | SID_W | Stream identifier of the current transaction |
| global_mode | input | 1 | 1: counter 0's filter applies to all counters; 0: per-counter filters |
| ctr_pattern | input | NUM_CTR*SID_W | Match pattern of each counter, counter i in slice i |
| ctr_span | input | NUM_CTR | Span flag of each counter, bit i for counter i |
| match_o | output | NUM_CTR | Per-counter match flag |

## Verification
Exact mode is tried with equal identifiers and with identifiers that differ only in bit 0 or only in the top bit, so a compare that drops an end bit cannot pass. Span mode is swept over all 33 positions of the lowest pattern zero. At each position, an identifier that differs only inside the wildcard run must match, and one that differs in the first bit above the run must miss. This pins the wildcard boundary to within one bit. The 0x42 example, an all-ones pattern, differing per-counter patterns and global scope with contradicting per-counter settings each separate one rule from its neighbours. A long random run against an independent loop-based model, a reset asserted mid-run and an explicit latency probe cover the remaining cases.

// File: rtl/sidf_pkg.sv
// Package: shared definitions for the stream identifier match filter.
// Assumes: the identifier width and counter count used by default are
// those below; the top module may override them through parameters.
package sidf_pkg;

    // Default identifier width in bits.
    localparam int DEF_SID_W   = 32;
    // Default number of event counters served.
    localparam int DEF_NUM_CTR = 4;

    // Where each counter's filter settings are taken from.
    typedef enum logic {
        SCOPE_PER_CTR = 1'b0,
        SCOPE_GLOBAL  = 1'b1
    } sidf_scope_e;

endpackage

// File: rtl/sidf_care_mask.sv
// Module: sidf_care_mask
// Builds the mask of identifier bits that take part in the comparison.
// In exact mode every bit is cared for. In span mode, bit i is a
// wildcard when all pattern bits below i are ones. The lowest zero of
// the pattern and everything beneath it are therefore don't-care, and a
// pattern with no zero makes the whole identifier a wildcard.
// Assumes: W >= 1; purely combinational.
module sidf_care_mask #(
    parameter int W = 32
) (
    input  logic [W-1:0] pattern,
    input  logic         span,
    output logic [W-1:0] care
);

    // ones_below[i] is 1 when pattern bits i-1..0 are all ones.
    logic [W:0] ones_below;

    assign ones_below[0] = 1'b1;

    for (genvar b = 0; b < W; b++) begin : g_chain
        // Extend the run of trailing ones by one bit position.
        assign ones_below[b+1] = ones_below[b] & pattern[b];
        // A bit is cared for unless span mode puts it inside the run.
        assign care[b] = ~span | ~ones_below[b];
    end

endmodule

// File: rtl/sidf_compare.sv
// Module: sidf_compare
// Reports a hit when the identifier equals the pattern on every bit that
// the care mask selects.
// Assumes: W >= 1; purely combinational.
module sidf_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] sid,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] care,
    output logic         hit
);

    logic [W-1:0] diff;

    // Mark bits that differ and are not wildcards.
    always_comb diff = (sid ^ pattern) & care;

    // A hit means no marked difference remains.
    always_comb hit = ~|diff;

endmodule

// File: rtl/sidf_scope_sel.sv
// Module: sidf_scope_sel
// Picks the pattern and span flag that filter each counter. In global
// scope every counter gets counter 0's settings; otherwise each counter
// keeps its own.
// Assumes: N >= 1, flat pattern vector with counter i in slice i.
module sidf_scope_sel
    import sidf_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N*W-1:0] pattern_in,
    input  logic [N-1:0]   span_in,
    input  logic           global_mode,
    output logic [N*W-1:0] pattern_out,
    output logic [N-1:0]   span_out
);

    sidf_scope_e scope;

    // Interpret the mode input as a scope selection.
    always_comb scope = sidf_scope_e'(global_mode);

    for (genvar i = 0; i < N; i++) begin : g_ctr
        // Route either counter 0's or this counter's settings.
        always_comb begin
            if (scope == SCOPE_GLOBAL) begin
                pattern_out[i*W +: W] = pattern_in[0 +: W];
                span_out[i]           = span_in[0];
            end else begin
                pattern_out[i*W +: W] = pattern_in[i*W +: W];
                span_out[i]           = span_in[i];
            end
        end
    end

endmodule

// File: rtl/sidf_stream_match.sv
// Module: sidf_stream_match (top)
// Per-counter stream identifier filter. It selects each counter's
// filter scope, builds its care mask, compares the identifier, and
// optionally registers the resulting flags.
// Assumes: synchronous active-low reset; OUT_REG is 0 or 1.
module sidf_stream_match
    import sidf_pkg::*;
#(
    parameter int NUM_CTR = DEF_NUM_CTR,
    parameter int SID_W   = DEF_SID_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SID_W-1:0]         evt_sid,
    input  logic                     global_mode,
    input  logic [NUM_CTR*SID_W-1:0] ctr_pattern,
    input  logic [NUM_CTR-1:0]       ctr_span,
    output logic [NUM_CTR-1:0]       match_o
);

    localparam int PAT_BITS = NUM_CTR * SID_W;

    logic [PAT_BITS-1:0] sel_pattern;
    logic [NUM_CTR-1:0]  sel_span;
    logic [PAT_BITS-1:0] care_all;
    logic [NUM_CTR-1:0]  hit_w;

    sidf_scope_sel #(
        .N (NUM_CTR),
        .W (SID_W)
    ) u_scope (
        .pattern_in  (ctr_pattern),
        .span_in     (ctr_span),
        .global_mode (global_mode),
        .pattern_out (sel_pattern),
        .span_out    (sel_span)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
        sidf_care_mask #(
            .W (SID_W)
        ) u_mask (
            .pattern (sel_pattern[i*SID_W +: SID_W]),
            .span    (sel_span[i]),
            .care    (care_all[i*SID_W +: SID_W])
        );

        sidf_compare #(
            .W (SID_W)
        ) u_cmp (
            .sid     (evt_sid),
            .pattern (sel_pattern[i*SID_W +: SID_W]),
            .care    (care_all[i*SID_W +: SID_W]),
            .hit     (hit_w[i])
        );
    end

    if (OUT_REG) begin : g_reg
        logic [NUM_CTR-1:0] match_q;

        // Hold the flags for one cycle to align with a registered strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                match_q <= '0;
            end else begin
                match_q <= hit_w;
            end
        end

        assign match_o = match_q;
    end else begin : g_comb
        assign match_o = hit_w;
    end

endmodule

// File: rtl/sidf_stream_match_chk.sv
// Module: sidf_stream_match_chk
// Assertion checker bound to sidf_stream_match. It relates the ports
// over time: exact-mode equality, the lowest-bit span case, all-ones
// wildcard, global scope uniformity and reset clearing.
// Assumes: same parameters as the bound instance.
module sidf_stream_match_chk #(
    parameter int NUM_CTR = 4,
    parameter int SID_W   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SID_W-1:0]         evt_sid,
    input logic                     global_mode,
    input logic [NUM_CTR*SID_W-1:0] ctr_pattern,
    input logic [NUM_CTR-1:0]       ctr_span,
    input logic [NUM_CTR-1:0]       match_o
);

    logic [SID_W-1:0] pat0;
    assign pat0 = ctr_pattern[0 +: SID_W];

    if (OUT_REG) begin : g_seq
        logic rst_low_q = 1'b0;

        // Remember whether the previous edge saw reset asserted.
        always_ff @(posedge clk) rst_low_q <= !rst_n;

        // Check flags cleared after a reset edge.
        always @(posedge clk) begin
            if (rst_low_q) begin
                AST_RESET_CLEAR: assert (match_o == '0); // R8
            end
        end

        AST_GLOBAL_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n) global_mode |=> (match_o == '0 || match_o == '1)); // R6

        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            logic [SID_W-1:0] pat_i;
            assign pat_i = ctr_pattern[i*SID_W +: SID_W];

            AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && !ctr_span[i] && evt_sid == pat_i) |=> match_o[i]); // R1
            AST_EXACT_MISS: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && !ctr_span[i] && evt_sid != pat_i) |=> !match_o[i]); // R1
            AST_SPAN_LSB: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && ctr_span[i] && !pat_i[0] && evt_sid[SID_W-1:1] == pat_i[SID_W-1:1]) |=> match_o[i]); // R2
            AST_ALL_WILD: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && ctr_span[i] && pat_i == '1) |=> match_o[i]); // R4
            AST_GLOBAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (global_mode && !ctr_span[0] && evt_sid == pat0) |=> match_o[i]); // R6
        end
    end else begin : g_cmb
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            logic [SID_W-1:0] pat_i;
            assign pat_i = ctr_pattern[i*SID_W +: SID_W];

            AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && !ctr_span[i] && evt_sid == pat_i) |-> match_o[i]); // R1
            AST_EXACT_MISS: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && !ctr_span[i] && evt_sid != pat_i) |-> !match_o[i]); // R1
            AST_ALL_WILD: assert property (@(posedge clk) disable iff (!rst_n) (!global_mode && ctr_span[i] && pat_i == '1) |-> match_o[i]); // R4
            AST_GLOBAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (global_mode && !ctr_span[0] && evt_sid == pat0) |-> match_o[i]); // R6
        end
    end

endmodule

bind sidf_stream_match sidf_stream_match_chk #(
    .NUM_CTR (NUM_CTR),
    .SID_W   (SID_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_sid     (evt_sid),
    .global_mode (global_mode),
    .ctr_pattern (ctr_pattern),
    .ctr_span    (ctr_span),
    .match_o     (match_o)
);

// File: tb/sidf_stream_match_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task pushes expected flags, and a monitor
// pops and compares them one cycle later.
module sidf_stream_match_tb;

    localparam int N = 4;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     evt_sid = '0;
    logic             global_mode = 1'b0;
    logic [N*W-1:0]   ctr_pattern = '0;
    logic [N-1:0]     ctr_span = '0;
    logic [N-1:0]     match_o;

    // 125 MHz clock.
    always #4 clk = ~clk;

    sidf_stream_match #(.NUM_CTR(N), .SID_W(W), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_sid(evt_sid), .global_mode(global_mode),
        .ctr_pattern(ctr_pattern), .ctr_span(ctr_span), .match_o(match_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] pat_a [N];
    logic [N-1:0] span_v = '0;
    logic [W-1:0] sid_n = '0;
    logic         glob_n = 1'b0;

    logic [N-1:0] exp_q [$];
    string        tag_q [$];

    // Reference model: find the wildcard run by scanning, then compare.
    function automatic logic ref_match(logic [W-1:0] s, logic [W-1:0] p, logic sp);
        int  y;
        bit  found;
        y = W;
        found = 0;
        if (!sp) return (s == p);
        for (int b = 0; b < W; b++) begin
            if (!found && !p[b]) begin
                y = b + 1;
                found = 1;
            end
        end
        for (int b = 0; b < W; b++) begin
            if (b >= y && s[b] != p[b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_now(string tag, logic [N-1:0] exp);
        checks++;
        if (match_o !== exp) begin
            fails++;
            $display("FAIL %s: match_o=%b expected=%b", tag, match_o, exp);
        end
    endtask

    // Drive the staged inputs at a falling edge and queue the expectation.
    task automatic step(string tag);
        logic [N-1:0] e;
        @(negedge clk);
        evt_sid     = sid_n;
        global_mode = glob_n;
        ctr_span    = span_v;
        for (int i = 0; i < N; i++) ctr_pattern[i*W +: W] = pat_a[i];
        for (int i = 0; i < N; i++) begin
            if (glob_n) e[i] = ref_match(sid_n, pat_a[0], span_v[0]);
            else        e[i] = ref_match(sid_n, pat_a[i], span_v[i]);
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic all_pat(logic [W-1:0] p, logic sp);
        for (int i = 0; i < N; i++) pat_a[i] = p;
        span_v = {N{sp}};
    endtask

    // Monitor: compare one queued expectation after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_now(t, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] p;
        logic [W-1:0] lowm;
        for (int i = 0; i < N; i++) pat_a[i] = '0;

        // R8: reset holds flags low even with an all-matching setting.
        all_pat('1, 1'b1);
        sid_n = 32'h1234_5678;
        @(negedge clk);
        evt_sid = sid_n; ctr_span = span_v;
        for (int i = 0; i < N; i++) ctr_pattern[i*W +: W] = pat_a[i];
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R8 reset state", '0);
        rst_n = 1'b1;

        // R1: exact mode equality and single-bit differences.
        all_pat(32'h1234_5678, 1'b0);
        sid_n = 32'h1234_5678; step("R1 exact equal");
        sid_n = 32'h1234_5679; step("R1 exact bit0 differs");
        sid_n = 32'h9234_5678; step("R1 exact bit31 differs");
        all_pat(32'h0, 1'b0);
        sid_n = 32'h0;         step("R1 exact zero");
        sid_n = 32'h1;         step("R1 exact zero vs one");

        // R3: pattern 0x42 in span mode.
        all_pat(32'h42, 1'b1);
        sid_n = 32'h40; step("R3 0x40");
        sid_n = 32'h41; step("R3 0x41");
        sid_n = 32'h42; step("R3 0x42");
        sid_n = 32'h43; step("R3 0x43");
        sid_n = 32'h44; step("R3 0x44");
        sid_n = 32'hC2; step("R3 0xC2");
        sid_n = 32'h8000_0042; step("R3 high bit");

        // R2: every position of the lowest zero, plus R4 for none.
        for (int k = 0; k <= W; k++) begin
            p = $urandom;
            if (k < W) begin
                lowm = (k == 0) ? '0 : ('1 >> (W - k));
                p = (p & ~lowm) | lowm;
                p[k] = 1'b0;
                lowm[k] = 1'b1;
            end else begin
                p = '1;
                lowm = '1;
            end
            all_pat(p, 1'b1);
            sid_n = p ^ (32'($urandom) & lowm);
            step(k < W ? "R2 inside run" : "R4 no zero");
            if (k + 1 < W) begin
                sid_n = p ^ (32'($urandom) & lowm);
                sid_n[k+1] = ~p[k+1];
                step("R2 first cared bit");
            end
        end

        // R4: all-ones pattern matches random identifiers.
        all_pat('1, 1'b1);
        for (int j = 0; j < 10; j++) begin
            sid_n = $urandom;
            step("R4 all ones");
        end

        // R5: each counter uses its own pattern and span.
        pat_a[0] = 32'hAAAA_0000; pat_a[1] = 32'h0000_00FE;
        pat_a[2] = 32'h5555_5555; pat_a[3] = 32'h0000_00F0;
        span_v = 4'b1010;
        sid_n = 32'h5555_5555; step("R5 own pattern lane2");
        sid_n = 32'h0000_00FF; step("R5 own span lane1");
        sid_n = 32'h0000_00F0; step("R5 exact lane3");
        sid_n = 32'hAAAA_0000; step("R5 exact lane0");

        // R6: global scope follows counter 0 only.
        glob_n = 1'b1;
        pat_a[0] = 32'h42; pat_a[1] = 32'h43; pat_a[2] = 32'h0; pat_a[3] = 32'h99;
        span_v = 4'b0001;
        sid_n = 32'h43; step("R6 global match");
        sid_n = 32'h0;  step("R6 global others ignored");
        span_v = 4'b1110;
        sid_n = 32'h43; step("R6 global exact via counter0");
        sid_n = 32'h42; step("R6 global exact hit");
        glob_n = 1'b0;

        // R7: flags change only at the rising edge after the inputs.
        all_pat(32'h77, 1'b0);
        sid_n = 32'h0; step("R7 setup miss");
        @(posedge clk); #2;
        @(negedge clk);
        evt_sid = 32'h77;
        #1;
        check_now("R7 no change before edge", '0);
        @(posedge clk); #1;
        check_now("R7 change after edge", '1);

        // R1/R2 random mix against the model.
        for (int j = 0; j < 300; j++) begin
            for (int i = 0; i < N; i++) begin
                pat_a[i] = $urandom;
                if ($urandom_range(0, 1) == 1)
                    pat_a[i] = pat_a[i] | ((32'h1 << $urandom_range(0, 31)) - 1);
            end
            span_v = 4'($urandom);
            glob_n = ($urandom_range(0, 3) == 0);
            sid_n  = ($urandom_range(0, 1) == 1) ? pat_a[$urandom_range(0, N-1)] ^ 32'($urandom_range(0, 7)) : 32'($urandom);
            step("R1 R2 random");
        end
        glob_n = 1'b0;

        // R8: reset in mid-run clears set flags.
        all_pat('1, 1'b1);
        sid_n = 32'h5; step("R4 before reset");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_now("R8 mid-run reset", '0);
        @(negedge clk);
        rst_n = 1'b1;

        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule